// File: doc/BRIEF.md
# Sequential Bit Deposit/Extract Unit

This block scatters or gathers bits of a W-bit source word under a W-bit mask, one mask bit per clock cycle. In deposit mode, the low-order source bits go to the positions where the mask has ones, from the lowest such position upward. In extract mode, the source bits at the mask's one positions are packed into a contiguous field that starts at result bit 0.

A single-cycle `start` pulse captures the source, the mask and the operation select. The engine then walks the mask. Each cycle it finds the lowest remaining one with a trailing-zero counter, moves one bit, and clears that one with `m & (m - 1)`. When no ones remain it raises `done` for one cycle and updates `result`. `result` holds that value until the next operation completes. A `start` that arrives while an operation is in flight is dropped.

Top module: `bitdx_unit`

## Requirements
- R1: After reset, `done` is 0 and `result` is all zeros.
- R2: With `op_sel` = 0 (deposit), source bit i goes to the position of the (i+1)-th lowest set bit of the mask.
- R3: With `op_sel` = 1 (extract), the source bit at the position of the (i+1)-th lowest set mask bit goes to result bit i.
- R4: A mask of all zeros gives an all-zero result, with `done` one cycle after the start edge.
- R5: Every result bit not written by a step is zero. In deposit mode these are the bits outside the mask. In extract mode these are the bits at and above the mask's population count.
- R6: `done` rises N+1 clock edges after the edge that samples `start`, where N is the number of ones in the mask.
- R7: `src`, `mask` and `op_sel` are sampled only at the accepted start edge. Changing them afterwards does not alter the result.
- R8: A `start` pulse that arrives before the current operation's `done` is ignored. It produces no extra `done` and does not change the result.
- R9: `done` is high for exactly one cycle per operation. `result` changes only in the cycle `done` is high and is stable otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; accepted only when idle |
| op_sel | input | 1 | 0 = deposit, 1 = extract |
| src | input | W | Source word |
| mask | input | W | Selection mask |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | Result of the most recent completed operation |

## Verification
The assertions assume that `start` is a single-cycle pulse from a driver that keeps the inputs stable only during that cycle. The zero-mask property also assumes the engine is idle when `start` is seen. The stimulus raises `start` for one cycle at a time and waits for `done` before a new operation. The only exception is the dedicated busy-collision test. That test pulses `start` mid-walk with a zero mask while the engine is busy, so the zero-mask property, which is gated by the idle state, is not triggered. The input values are changed right after the start edge to show they were captured.

// File: rtl/bitdx_pkg.sv
package bitdx_pkg;
  typedef enum logic {
    OP_DEPOSIT = 1'b0,
    OP_EXTRACT = 1'b1
  } bitdx_op_e;
endpackage

// File: rtl/bitdx_tzc.sv
// Trailing-zero counter: returns W when the input is all zeros.
module bitdx_tzc #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = CW'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) cnt = CW'(i);
    end
  end
endmodule

// File: rtl/bitdx_step.sv
// One iteration: move a single bit and retire the lowest set mask bit.
module bitdx_step
  import bitdx_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  bitdx_op_e     op,
  input  logic [W-1:0]  src,
  input  logic [W-1:0]  mask_rem,
  input  logic [CW-1:0] idx,
  input  logic [W-1:0]  acc,
  output logic [CW-1:0] pos,
  output logic [W-1:0]  acc_next,
  output logic [W-1:0]  mask_next
);
  logic [CW-1:0] rd_sel;
  logic [CW-1:0] wr_sel;
  logic          bit_val;

  bitdx_tzc #(.W(W), .CW(CW)) tzc_i (
    .vec (mask_rem),
    .cnt (pos)
  );

  assign rd_sel    = (op == OP_DEPOSIT) ? idx : pos;
  assign wr_sel    = (op == OP_DEPOSIT) ? pos : idx;
  assign mask_next = mask_rem & (mask_rem - 1'b1);

  always_comb begin
    bit_val = 1'b0;
    for (int j = 0; j < W; j++) begin
      if (rd_sel == CW'(j)) bit_val = src[j];
    end
  end

  // A position equal to W (empty mask) matches no lane, so nothing is written.
  always_comb begin
    acc_next = acc;
    for (int j = 0; j < W; j++) begin
      if (wr_sel == CW'(j)) acc_next[j] = bit_val;
    end
  end
endmodule

// File: rtl/bitdx_unit.sv
module bitdx_unit
  import bitdx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         op_sel,
  input  logic [W-1:0] src,
  input  logic [W-1:0] mask,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int CW = $clog2(W + 1);

  logic          busy;
  bitdx_op_e     op_q;
  logic [W-1:0]  src_q;
  logic [W-1:0]  mask_rem;
  logic [CW-1:0] idx;
  logic [W-1:0]  acc;
  logic [CW-1:0] tz_pos;
  logic [W-1:0]  acc_n;
  logic [W-1:0]  mask_n;

  bitdx_step #(.W(W), .CW(CW)) step_i (
    .op        (op_q),
    .src       (src_q),
    .mask_rem  (mask_rem),
    .idx       (idx),
    .acc       (acc),
    .pos       (tz_pos),
    .acc_next  (acc_n),
    .mask_next (mask_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      result   <= '0;
      op_q     <= OP_DEPOSIT;
      src_q    <= '0;
      mask_rem <= '0;
      idx      <= '0;
      acc      <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          op_q     <= bitdx_op_e'(op_sel);
          src_q    <= src;
          mask_rem <= mask;
          idx      <= '0;
          acc      <= '0;
        end
      end else if (mask_rem == '0) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        result <= acc;
      end else begin
        acc      <= acc_n;
        mask_rem <= mask_n;
        idx      <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bitdx_chk.sv
module bitdx_chk #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [W-1:0]  mask,
  input logic          done,
  input logic [W-1:0]  result,
  input logic          busy,
  input logic [W-1:0]  mask_rem,
  input logic [CW-1:0] tz_pos
);
  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: result only moves when done is raised
  p_result_stable_r9: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  // R4: empty mask completes one cycle after the start edge with zero result
  p_zero_mask_r4: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && mask == '0) |-> ##2 (done && result == '0));

  // R6: the walk ends only by completing
  p_finish_done_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R5: the finder never reports an out-of-range position while ones remain
  p_tz_range_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && mask_rem != '0) |-> (tz_pos < CW'(W)));

  // R1: no completion while resetting
  always @(posedge clk) begin
    if (rst) p_reset_done_r1: assert (!done || $past(!rst));
  end
endmodule

bind bitdx_unit bitdx_chk #(.W(W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .mask     (mask),
  .done     (done),
  .result   (result),
  .busy     (busy),
  .mask_rem (mask_rem),
  .tz_pos   (tz_pos)
);

// File: tb/bitdx_unit_tb_top.sv
module bitdx_unit_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         op_sel = 1'b0;
  logic [W-1:0] src = '0;
  logic [W-1:0] mask = '0;
  logic         done;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bitdx_unit #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .op_sel(op_sel),
    .src(src), .mask(mask), .done(done), .result(result)
  );

  function automatic logic [W-1:0] model(input logic op, input logic [W-1:0] s,
                                         input logic [W-1:0] m);
    logic [W-1:0] r = '0;
    int k = 0;
    for (int j = 0; j < W; j++) begin
      if (m[j]) begin
        if (!op) r[j] = s[k];
        else     r[k] = s[j];
        k++;
      end
    end
    return r;
  endfunction

  function automatic int popc(input logic [W-1:0] m);
    int n = 0;
    for (int j = 0; j < W; j++) n += int'(m[j]);
    return n;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one operation, scramble the inputs after capture, measure latency.
  task automatic run_op(input string req, input logic op, input logic [W-1:0] s,
                        input logic [W-1:0] m);
    int lat = 0;
    logic [W-1:0] prev;
    @(negedge clk);
    op_sel = op; src = s; mask = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0; op_sel = ~op; src = ~s; mask = ~m;  // R7: must not matter
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check({req, " R6 latency"}, W'(lat), W'(popc(m) + 1));
    check({req, " R7 result"}, result, model(op, s, m));
    prev = result;
    @(negedge clk);
    check({req, " R9 done pulse"}, W'(done), '0);
    check({req, " R9 stable"}, result, prev);
  endtask

  task automatic test_reset();
    check("R1 done", W'(done), '0);
    check("R1 result", result, '0);
  endtask

  task automatic test_deposit();
    run_op("R2 sparse", 1'b0, 16'hABCD, 16'h0F0F);
    run_op("R2 full", 1'b0, 16'h5A3C, 16'hFFFF);
    run_op("R5 deposit top", 1'b0, 16'hFFFF, 16'h8001);
    check("R5 outside mask zero", result & ~16'h8001, '0);
  endtask

  task automatic test_extract();
    run_op("R3 sparse", 1'b1, 16'hABCD, 16'hF00F);
    run_op("R3 full", 1'b1, 16'h1234, 16'hFFFF);
    run_op("R5 extract high", 1'b1, 16'hFFFF, 16'h0210);
    check("R5 above count zero", result & 16'hFFFC, '0);
  endtask

  task automatic test_zero_mask();
    run_op("R4 deposit", 1'b0, 16'hFFFF, 16'h0000);
    check("R4 zero", result, '0);
    run_op("R4 extract", 1'b1, 16'hFFFF, 16'h0000);
  endtask

  task automatic test_busy_start();
    int lat = 0;
    int dones = 0;
    @(negedge clk);
    op_sel = 1'b0; src = 16'h00C5; mask = 16'hFF00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    lat = 1;
    op_sel = 1'b1; src = 16'hFFFF; mask = 16'h0000; start = 1'b1;  // R8: ignored
    @(negedge clk);
    lat = 2;
    start = 1'b0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check("R8 latency", W'(lat), W'(9));
    check("R8 result", result, model(1'b0, 16'h00C5, 16'hFF00));
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      dones += int'(done);
    end
    check("R8 no extra done", W'(dones), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst = 1'b0;
    test_deposit();
    test_extract();
    test_zero_mask();
    test_busy_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule